// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a clocked behavioural model of a synchronous static memory with a 32-bit word split into four 8-bit lanes. A new access starts when one of two address strobes is asserted while the device is selected. The processor-side strobe counts only when the master select is active. The controller-side strobe counts regardless of the master select, and it deselects the device when any select is wrong. After an access starts, an advance input walks a 2-bit burst counter through a four-word aligned block. A static mode input chooses between plain increment order and XOR-interleaved order.

Every clock edge on which the device is active performs one access at the current burst address. The write inputs decide whether that access is a write and which lanes it changes. These inputs form three levels: a global write, a byte-write enable, and one enable per lane. Read results pass through one output register in flow-through mode, or through two registers in pipelined mode. An asynchronous output enable decides whether the read result is driven.

Top module: `burst_sram`

## Requirements
- R1: When either strobe is accepted (low) with all three selects valid (master low, high-side select high, low-side select low), the device becomes active and the access on that edge uses the address on `addr`.
- R2: While `sel_main_n` is high, `strobe_cpu_n` has no effect. With `strobe_ctl_n` high, the edge behaves as a non-strobe cycle, so a running burst keeps going.
- R3: An accepted strobe with a wrong select (any of the three for the controller strobe, or the two secondary ones for the processor strobe) deselects the device. While deselected, no write and no read takes place, even when `adv_n` is low, until a qualified strobe arrives.
- R4: On an edge with no accepted strobe, `adv_n` low moves to the next burst address. `adv_n` high repeats the access at the current address.
- R5: With `xor_order` low, the low two address bits of the k-th access of a burst equal (start + k) mod 4. Address bits above bit 1 never change without a strobe.
- R6: With `xor_order` high, the low two address bits of the k-th access equal start XOR k.
- R7: `wr_all_n` low makes the access a write of all four lanes, whatever `byte_wr_en_n` and `lane_wr_n` are.
- R8: With `wr_all_n` high and `byte_wr_en_n` low, lane i (data bits 8i+7 down to 8i) is written if and only if `lane_wr_n[i]` is low.
- R9: With `wr_all_n` high and either `byte_wr_en_n` high or all `lane_wr_n` bits high, the access is a read and the memory is unchanged.
- R10: `bus_en` is high only while `out_en_n` is low and a read result is being presented. It follows `out_en_n` without a clock. `rd_data` is zero whenever `bus_en` is low.
- R11: With `flow_thru_n` low, a read's data is presented right after the edge that performs it. With `flow_thru_n` high, it is presented one edge later.
- R12: During and after synchronous reset (`rst` high), the device is deselected and `bus_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Start address taken by an accepted strobe |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| sel_main_n | input | 1 | Master select, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| byte_wr_en_n | input | 1 | Enables the per-lane write inputs, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| xor_order | input | 1 | Burst order: high interleaved, low linear (static) |
| flow_thru_n | input | 1 | Low selects one output stage, high two (static) |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Read data, zero when not driven |
| bus_en | output | 1 | High while the read data bus is driven |

## Verification
Each start offset in both orders is checked against hand-derived address sequences. A counter that wraps past the aligned block, or that adds where it should XOR, returns words from the wrong slot. A processor strobe with the master select high is driven in the middle of a burst, so a design that still honours it jumps to the new address and not to the next burst word. Deselection by a bad secondary select is followed by advancing write cycles, and those words are read back, so a design that keeps writing while deselected corrupts them. Reads with the lane enables low but the byte enable high, and a write with the global enable low but some lane enables high, expose a decoder that gives the wrong level priority. Both latency modes and the asynchronous enable are compared on every cycle, so a pipeline off by one stage shows at once.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ACC_HOLD,
        ACC_STEP,
        ACC_LOAD,
        ACC_DESEL
    } acc_op_e;

    typedef struct packed {
        logic [BURST_W-1:0] base;
        logic [BURST_W-1:0] cnt;
    } burst_pos_t;

    // Low address bits for a burst position in either count order.
    function automatic logic [BURST_W-1:0] burst_slot(input burst_pos_t p, input logic interleave);
        logic [BURST_W-1:0] r;
        if (interleave) r = p.base ^ p.cnt;
        else            r = p.base + p.cnt;
        return r;
    endfunction

endpackage

// File: rtl/bsr_addr_ctl.sv
module bsr_addr_ctl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_n,
    input  logic              ctl_n,
    input  logic              main_n,
    input  logic              hi,
    input  logic              lo_n,
    input  logic              adv_n,
    input  logic              interleave,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              eff_active
);

    localparam int UPPER_W = ADDR_W - BURST_W;

    logic [UPPER_W-1:0] upper_q, upper_d;
    burst_pos_t         pos_q, pos_d;
    logic               active_q, active_d;
    logic               full_sel, cpu_take;
    acc_op_e            op;

    // Strobe priority: a qualified processor strobe first, then the controller strobe.
    always_comb begin
        full_sel = hi && !lo_n;
        cpu_take = !cpu_n && !main_n;
        if (cpu_take)
            op = full_sel ? ACC_LOAD : ACC_DESEL;
        else if (!ctl_n)
            op = (!main_n && full_sel) ? ACC_LOAD : ACC_DESEL;
        else if (!adv_n)
            op = ACC_STEP;
        else
            op = ACC_HOLD;
    end

    always_comb begin
        upper_d  = upper_q;
        pos_d    = pos_q;
        active_d = active_q;
        unique case (op)
            ACC_LOAD: begin
                upper_d    = addr_in[ADDR_W-1:BURST_W];
                pos_d.base = addr_in[BURST_W-1:0];
                pos_d.cnt  = '0;
                active_d   = 1'b1;
            end
            ACC_STEP:  pos_d.cnt = pos_q.cnt + BURST_W'(1);
            ACC_DESEL: active_d  = 1'b0;
            default:   ;
        endcase
    end

    // The access on this edge uses the updated position.
    assign eff_addr   = {upper_d, burst_slot(pos_d, interleave)};
    assign eff_active = active_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q  <= '0;
            pos_q    <= '0;
            active_q <= 1'b0;
        end else begin
            upper_q  <= upper_d;
            pos_q    <= pos_d;
            active_q <= active_d;
        end
    end

endmodule

// File: rtl/bsr_wr_decode.sv
module bsr_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             byte_en_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we,
    output logic             is_write
);

    // Global write outranks the byte-enable level, which gates the lane level.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !wr_all_n || (!byte_en_n && !lane_n[g]);
    end

    assign is_write = |lane_we;

endmodule

// File: rtl/bsr_store.sv
module bsr_store #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_active,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic                    is_write,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    flow_thru_n,
    input  logic                    out_en_n,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    bus_en
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic              rd;
        logic [DATA_W-1:0] data;
    } stage_t;

    logic [DATA_W-1:0] lane_rd;
    logic              rd_go;
    stage_t            s1, s2, sel;

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (acc_active && lane_we[g])
                mem[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
        end
        assign lane_rd[g*LANE_W +: LANE_W] = mem[acc_addr];
    end

    assign rd_go = acc_active && !is_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1.rd <= rd_go;
            if (rd_go) s1.data <= lane_rd;
            s2 <= s1;
        end
    end

    assign sel     = flow_thru_n ? s2 : s1;
    assign bus_en  = !out_en_n && sel.rd;
    assign rd_data = bus_en ? sel.data : '0;

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    sel_main_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    byte_wr_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    input  logic                    xor_order,
    input  logic                    flow_thru_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    bus_en
);

    logic [ADDR_W-1:0] eff_addr;
    logic              eff_active;
    logic [LANES-1:0]  lane_we;
    logic              is_write;

    bsr_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .addr_in    (addr),
        .cpu_n      (strobe_cpu_n),
        .ctl_n      (strobe_ctl_n),
        .main_n     (sel_main_n),
        .hi         (sel_hi),
        .lo_n       (sel_lo_n),
        .adv_n      (adv_n),
        .interleave (xor_order),
        .eff_addr   (eff_addr),
        .eff_active (eff_active)
    );

    bsr_wr_decode #(.LANES(LANES)) u_wdec (
        .wr_all_n  (wr_all_n),
        .byte_en_n (byte_wr_en_n),
        .lane_n    (lane_wr_n),
        .lane_we   (lane_we),
        .is_write  (is_write)
    );

    bsr_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .acc_active  (eff_active),
        .acc_addr    (eff_addr),
        .lane_we     (lane_we),
        .is_write    (is_write),
        .wr_data     (wr_data),
        .flow_thru_n (flow_thru_n),
        .out_en_n    (out_en_n),
        .rd_data     (rd_data),
        .bus_en      (bus_en)
    );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    strobe_cpu_n,
    input logic                    strobe_ctl_n,
    input logic                    sel_main_n,
    input logic                    wr_all_n,
    input logic                    byte_wr_en_n,
    input logic [LANES-1:0]        lane_wr_n,
    input logic                    out_en_n,
    input logic                    flow_thru_n,
    input logic                    bus_en,
    input logic [LANES*LANE_W-1:0] rd_data,
    input logic                    eff_active,
    input logic [ADDR_W-1:0]       eff_addr,
    input logic [LANES-1:0]        lane_we
);

    AST_BUS_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !bus_en); // R10

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_en |-> (rd_data == '0)); // R10

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        !wr_all_n |-> (&lane_we)); // R7

    AST_READ_NO_LANE: assert property (@(posedge clk) disable iff (rst)
        (wr_all_n && (byte_wr_en_n || (&lane_wr_n))) |-> (lane_we == '0)); // R9

    AST_FT_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !flow_thru_n && !out_en_n && $past(eff_active && !(|lane_we)))
        |-> bus_en); // R11

    AST_PIPE_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && flow_thru_n && !out_en_n
         && $past(eff_active && !(|lane_we), 2))
        |-> bus_en); // R11

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (strobe_cpu_n || sel_main_n) && strobe_ctl_n)
        |-> (eff_addr[ADDR_W-1:BURST_W] == $past(eff_addr[ADDR_W-1:BURST_W]))); // R5

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/burst_sram_test.sv
module burst_sram_test;

    localparam int AW = 8;
    localparam logic [AW-1:0] BASE = 8'h10;
    // {xor_order, start offset, four expected low-bit slots in access order}
    localparam logic [10:0] BURST_VEC [8] = '{
        {1'b0, 2'd0, 8'b00_01_10_11},
        {1'b0, 2'd1, 8'b01_10_11_00},
        {1'b0, 2'd2, 8'b10_11_00_01},
        {1'b0, 2'd3, 8'b11_00_01_10},
        {1'b1, 2'd0, 8'b00_01_10_11},
        {1'b1, 2'd1, 8'b01_00_11_10},
        {1'b1, 2'd2, 8'b10_11_00_01},
        {1'b1, 2'd3, 8'b11_10_01_00}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          strobe_cpu_n, strobe_ctl_n, sel_main_n, sel_hi, sel_lo_n, adv_n;
    logic          wr_all_n, byte_wr_en_n;
    logic [3:0]    lane_wr_n;
    logic          out_en_n, xor_order, flow_thru_n;
    logic [31:0]   wr_data, rd_data;
    logic          bus_en;

    int          checks = 0;
    int          failures = 0;
    bit          done = 0;
    logic        prev_rd;
    logic [31:0] prev_val;
    logic [31:0] ref_mem [256];

    always #5 clk = ~clk;

    burst_sram uut (
        .clk(clk), .rst(rst), .addr(addr),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .sel_main_n(sel_main_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .adv_n(adv_n), .wr_all_n(wr_all_n), .byte_wr_en_n(byte_wr_en_n),
        .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .xor_order(xor_order),
        .flow_thru_n(flow_thru_n), .wr_data(wr_data),
        .rd_data(rd_data), .bus_en(bus_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        strobe_cpu_n = 1; strobe_ctl_n = 1;
        sel_main_n = 0; sel_hi = 1; sel_lo_n = 0;
        adv_n = 1; wr_all_n = 1; byte_wr_en_n = 1; lane_wr_n = 4'hF;
        wr_data = '0; addr = '0;
    endtask

    // One clock: erd/ev describe the access issued with the current inputs.
    task automatic tick(input logic erd, input logic [31:0] ev, input string req);
        logic        cur_rd;
        logic [31:0] cur_val;
        @(posedge clk);
        @(negedge clk);
        if (!flow_thru_n) begin
            cur_rd = erd; cur_val = ev;
        end else begin
            cur_rd = prev_rd; cur_val = prev_val;
        end
        prev_rd = erd; prev_val = ev;
        chk({req, " bus_en"}, {31'd0, bus_en}, {31'd0, cur_rd && !out_en_n});
        chk({req, " rd_data"}, rd_data, (cur_rd && !out_en_n) ? cur_val : 32'd0);
        idle_inputs();
    endtask

    task automatic desel();
        strobe_ctl_n = 0; sel_main_n = 1;
        tick(0, 0, "R3");
    endtask

    task automatic wr_word(input logic [AW-1:0] a, input logic [31:0] d, input string req);
        strobe_ctl_n = 0; addr = a; wr_all_n = 0; wr_data = d;
        ref_mem[a] = d;
        tick(0, 0, req);
    endtask

    task automatic rd_start(input logic [AW-1:0] a, input bit use_cpu, input string req);
        if (use_cpu) strobe_cpu_n = 0; else strobe_ctl_n = 0;
        addr = a;
        tick(1, ref_mem[a], req);
    endtask

    task automatic rd_next(input logic [AW-1:0] a, input string req);
        adv_n = 0;
        tick(1, ref_mem[a], req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [10:0] v;
        logic [31:0] nv;
        rst = 1; idle_inputs();
        out_en_n = 0; xor_order = 1; flow_thru_n = 0;
        prev_rd = 0; prev_val = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset bus_en", {31'd0, bus_en}, 32'd0);
        chk("R12 reset rd_data", rd_data, 32'd0);
        rst = 0;
        tick(0, 0, "R12");               // no strobe yet: stays deselected

        // Fill one aligned block; global write wins over byte-level inputs
        for (int k = 0; k < 4; k++)
            wr_word(BASE + AW'(k), 32'hC0DE0000 + 32'(k) * 32'h01010101, "R7");
        strobe_cpu_n = 0; addr = BASE + 8'd2; wr_all_n = 0;
        byte_wr_en_n = 0; lane_wr_n = 4'b1110; wr_data = 32'h5A5A5A5A;
        ref_mem[BASE + 8'd2] = 32'h5A5A5A5A;
        tick(0, 0, "R7");

        // Burst order table, both orders from every offset
        for (int i = 0; i < 8; i++) begin
            v = BURST_VEC[i];
            desel();
            xor_order = v[10];
            rd_start(BASE | AW'(v[9:8]), i[0], "R1");
            chk("R1 table start slot", {30'd0, v[7:6]}, {30'd0, v[9:8]});
            for (int k = 1; k < 4; k++)
                rd_next(BASE | AW'(v[7-2*k -: 2]), v[10] ? "R6" : "R5");
        end
        desel();
        xor_order = 0;

        // Byte lane writes: lanes 1 and 3 only
        strobe_cpu_n = 0; addr = BASE + 8'd1; byte_wr_en_n = 0;
        lane_wr_n = 4'b0101; wr_data = 32'h11223344;
        nv = ref_mem[BASE + 8'd1];
        for (int l = 0; l < 4; l++)
            if (!lane_wr_n[l]) nv[8*l +: 8] = wr_data[8*l +: 8];
        ref_mem[BASE + 8'd1] = nv;
        tick(0, 0, "R8");
        rd_start(BASE + 8'd1, 0, "R8");

        // Read cycles despite low lane enables / with all lane enables high
        strobe_ctl_n = 0; addr = BASE + 8'd3; lane_wr_n = 4'h0; wr_data = 32'hFFFFFFFF;
        tick(1, ref_mem[BASE + 8'd3], "R9");
        byte_wr_en_n = 0; lane_wr_n = 4'hF; wr_data = 32'hFFFFFFFF;
        tick(1, ref_mem[BASE + 8'd3], "R9");  // held address, still a read
        rd_start(BASE + 8'd3, 1, "R9");

        // Blocked processor strobe mid-burst, then hold
        rd_start(BASE, 1, "R2");
        strobe_cpu_n = 0; sel_main_n = 1; addr = 8'h20; adv_n = 0;
        tick(1, ref_mem[BASE + 8'd1], "R2");
        tick(1, ref_mem[BASE + 8'd1], "R4");
        rd_next(BASE + 8'd2, "R4");

        // Deselect by secondary selects; advancing writes must be dropped
        strobe_cpu_n = 0; addr = BASE; sel_hi = 0;
        tick(0, 0, "R3");
        adv_n = 0; wr_all_n = 0; wr_data = 32'hDEADBEEF;
        tick(0, 0, "R3");
        rd_start(BASE + 8'd1, 0, "R3");      // mid-burst deselect below
        strobe_ctl_n = 0; sel_lo_n = 1; addr = BASE + 8'd3; wr_all_n = 0; wr_data = 32'hBAD0BAD0;
        tick(0, 0, "R3");
        adv_n = 0; wr_all_n = 0; wr_data = 32'hBAD1BAD1;
        tick(0, 0, "R3");
        rd_start(BASE, 0, "R3");
        for (int k = 1; k < 4; k++) rd_next(BASE + AW'(k), "R3");

        // Interleaved write burst from offset 2, read back linearly
        xor_order = 1;
        strobe_ctl_n = 0; addr = 8'h36; wr_all_n = 0; wr_data = 32'hA0000000;
        ref_mem[8'h36] = 32'hA0000000; tick(0, 0, "R6");
        adv_n = 0; wr_all_n = 0; wr_data = 32'hA1111111;
        ref_mem[8'h37] = 32'hA1111111; tick(0, 0, "R6");
        adv_n = 0; wr_all_n = 0; wr_data = 32'hA2222222;
        ref_mem[8'h34] = 32'hA2222222; tick(0, 0, "R6");
        adv_n = 0; wr_all_n = 0; wr_data = 32'hA3333333;
        ref_mem[8'h35] = 32'hA3333333; tick(0, 0, "R4");
        desel();
        xor_order = 0;
        rd_start(8'h34, 1, "R5");
        rd_next(8'h35, "R5");

        // Output enable: clocked and asynchronous
        out_en_n = 1; adv_n = 0;
        tick(1, ref_mem[8'h36], "R10");
        out_en_n = 0; #1;
        chk("R10 async enable bus_en", {31'd0, bus_en}, 32'd1);
        chk("R10 async enable rd_data", rd_data, ref_mem[8'h36]);
        out_en_n = 1; #1;
        chk("R10 async disable bus_en", {31'd0, bus_en}, 32'd0);
        chk("R10 async disable rd_data", rd_data, 32'd0);
        out_en_n = 0;
        desel();
        desel();

        // Pipelined mode: one more edge of latency
        flow_thru_n = 1;
        rd_start(8'h34, 0, "R11");
        rd_next(8'h35, "R11");
        rd_next(8'h36, "R11");
        desel();
        desel();
        wr_word(8'h20, 32'h0BADF00D, "R11");
        rd_start(8'h20, 1, "R11");
        desel();

        // Reset in the middle of a read
        rd_start(BASE, 0, "R12");
        rst = 1;
        @(posedge clk); @(negedge clk);
        chk("R12 mid reset bus_en", {31'd0, bus_en}, 32'd0);
        chk("R12 mid reset rd_data", rd_data, 32'd0);
        rst = 0; prev_rd = 0; prev_val = 0;
        tick(0, 0, "R12");
        tick(0, 0, "R12");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule